// File: doc/BRIEF.md
# Clocked Serial Shifter with Tail Mark

The block is a synchronous serial transfer engine. Software loads one or two data bytes over a small register bus and sets a start bit. The engine then drives its own serial clock and moves the data out on a serial output, least significant bit first. In the same clock periods it takes bits in from the serial input. In wide mode the upper byte register and the lower byte register form one 16-bit chain: the lower byte goes out first and the upper byte refills it.

An optional tail phase follows the last data bit. It sends a fixed two-bit marker, a 1 and then a 0. A read-only status bit is high for the whole tail phase. The start bit stays high until the tail phase, or the data phase when no tail is enabled, has finished, so software can poll it as a busy bit. A one-cycle done strobe marks the end of each transfer.

Register map (bus address): 0 is the control/status register, 1 is the upper byte, 2 is the lower byte. Control bits: bit 0 start/busy, bit 1 tail-active (read-only), bit 2 wide mode, bit 3 tail enable. The serial clock period is `CLK_DIV` system clocks.

Top module: `serial_xfer_unit`

## Requirements
- R1: After reset the control register (address 0) reads 0, the serial clock and serial data output are high, and the done strobe is low.
- R2: A bus write to address 0 with bit 0 set while idle starts a transfer. Bit 0 then reads 1 for exactly (data bits + tail bits) × `CLK_DIV` clock cycles and returns to 0 by itself.
- R3: Writing 0 to bit 0 starts nothing. Every control write that arrives while bit 0 reads 1 is ignored, including one that is captured on the edge where the transfer ends. Bits 2 and 3 are writable while idle.
- R4: In 8-bit mode (bit 2 = 0) the lower byte appears on the serial output least significant bit first, one bit per serial clock period. The output changes at the falling serial clock edge and is stable at the rising edge.
- R5: In 16-bit mode (bit 2 = 1) the output sends the lower byte's bits 0..7 and then the upper byte's bits 0..7, because the upper byte shifts into the lower byte's MSB end.
- R6: At each rising serial clock edge the input bit enters the MSB end of the shift path: the upper byte in 16-bit mode, or the lower byte in 8-bit mode, where the upper byte keeps its value. With the output looped back, both bytes end the transfer holding their original values.
- R7: With bit 3 set, two extra serial clock periods follow the data, carrying 1 and then 0 on the output.
- R8: Bit 1 reads 1 only during the tail phase, for 2×`CLK_DIV` − `CLK_DIV`/2 cycles. It reads 0 when idle, during the data phase, and in transfers without a tail.
- R9: Bit 1 is read-only. A bus write of 1 to it leaves it reading 0.
- R10: The done output pulses for exactly one cycle per transfer. The pulse falls in the first cycle in which bit 0 reads 0.
- R11: The serial clock is high whenever no transfer is running. It gives exactly one rising edge per data or tail bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 upper, 2 lower) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data output |
| sdi_i | input | 1 | Serial data input |
| done_o | output | 1 | One-cycle transfer-done strobe |

## Verification
The end of a transfer and a software control write can fall on the same clock edge. On that edge the busy bit clears, the done strobe rises, and a write could start a new transfer or change the mode bits. The bench counts the known transfer length and times a write of start, wide and tail so that it is captured exactly on the finishing edge. It then judges the result: the done strobe fires once, no serial clock edge follows, and the control register reads 0, which shows that the write was dropped as a write during the busy phase.

// File: rtl/sxu_pkg.sv
package sxu_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_TAIL = 2'd2
  } phase_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_UPPER = 2'd1;
  localparam logic [1:0] ADDR_LOWER = 2'd2;

  localparam int CTRL_START  = 0;
  localparam int CTRL_TAILST = 1;
  localparam int CTRL_WIDE   = 2;
  localparam int CTRL_TAILEN = 3;

  localparam int TAIL_LEN = 2;
endpackage

// File: rtl/sxu_rst_sync.sv
module sxu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/sxu_clkgen.sv
module sxu_clkgen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic fall_evt,
  output logic rise_evt,
  output logic sclk
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             sclk_q, sclk_n;
  logic             tick;

  assign tick = run && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_n  = cnt_q;
    sclk_n = sclk_q;
    if (!run) begin
      cnt_n  = '0;
      sclk_n = 1'b1;
    end else if (tick) begin
      cnt_n  = '0;
      sclk_n = ~sclk_q;
    end else begin
      cnt_n  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_n;
      sclk_q <= sclk_n;
    end
  end

  assign fall_evt = tick && sclk_q;
  assign rise_evt = tick && !sclk_q;
  assign sclk     = sclk_q;
endmodule

// File: rtl/sxu_seq.sv
module sxu_seq
  import sxu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_req,
  input  logic   wide,
  input  logic   tail_en,
  input  logic   fall_evt,
  input  logic   rise_evt,
  input  logic   lsb_i,
  output logic   busy,
  output phase_e phase,
  output logic   shift_en,
  output logic   sdo,
  output logic   done
);
  localparam int SLOT_W = $clog2(2 * DATA_W + TAIL_LEN + 1);

  logic          busy_q, busy_n;
  phase_e        phase_q, phase_n;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic          sdo_q, sdo_n;
  logic          done_q, done_n;
  logic [SLOT_W-1:0] nbits, last_slot;
  logic          in_data;

  assign nbits     = wide ? SLOT_W'(2 * DATA_W) : SLOT_W'(DATA_W);
  assign last_slot = nbits + (tail_en ? SLOT_W'(TAIL_LEN) : SLOT_W'(0)) - SLOT_W'(1);
  assign in_data   = slot_q < nbits;

  always_comb begin
    busy_n  = busy_q;
    phase_n = phase_q;
    slot_n  = slot_q;
    sdo_n   = sdo_q;
    done_n  = 1'b0;
    if (start_req) begin
      busy_n  = 1'b1;
      phase_n = PH_DATA;
      slot_n  = '0;
    end else if (busy_q) begin
      if (fall_evt) begin
        if (in_data) begin
          sdo_n   = lsb_i;
          phase_n = PH_DATA;
        end else begin
          sdo_n   = (slot_q == nbits);
          phase_n = PH_TAIL;
        end
      end
      if (rise_evt) begin
        if (slot_q == last_slot) begin
          busy_n  = 1'b0;
          phase_n = PH_IDLE;
          slot_n  = '0;
          done_n  = 1'b1;
        end else begin
          slot_n = slot_q + SLOT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= PH_IDLE;
      slot_q  <= '0;
      sdo_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_n;
      phase_q <= phase_n;
      slot_q  <= slot_n;
      sdo_q   <= sdo_n;
      done_q  <= done_n;
    end
  end

  assign busy     = busy_q;
  assign phase    = phase_q;
  assign shift_en = busy_q && rise_evt && in_data;
  assign sdo      = sdo_q;
  assign done     = done_q;
endmodule

// File: rtl/sxu_shifter.sv
module sxu_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_upper,
  input  logic              wr_lower,
  input  logic [DATA_W-1:0] wdata,
  input  logic              shift_en,
  input  logic              wide,
  input  logic              sdi,
  output logic [DATA_W-1:0] upper,
  output logic [DATA_W-1:0] lower
);
  logic [DATA_W-1:0] upper_q, upper_n;
  logic [DATA_W-1:0] lower_q, lower_n;
  logic              lower_feed;

  assign lower_feed = wide ? upper_q[0] : sdi;

  always_comb begin
    upper_n = upper_q;
    lower_n = lower_q;
    if (shift_en) begin
      lower_n = {lower_feed, lower_q[DATA_W-1:1]};
      if (wide) upper_n = {sdi, upper_q[DATA_W-1:1]};
    end else begin
      if (wr_upper) upper_n = wdata;
      if (wr_lower) lower_n = wdata;
    end
  end

  always_ff @(posedge clk) begin
    upper_q <= upper_n;
    lower_q <= lower_n;
  end

  assign upper = upper_q;
  assign lower = lower_q;
endmodule

// File: rtl/serial_xfer_unit.sv
module serial_xfer_unit
  import sxu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sclk_o,
  output logic              sdo_o,
  input  logic              sdi_i,
  output logic              done_o
);
  logic              rst_s_n;
  logic              wide_q, wide_n;
  logic              tail_en_q, tail_en_n;
  logic              ctrl_wr, start_req;
  logic              busy, shift_en, tail_flag;
  logic              fall_evt, rise_evt;
  phase_e            phase;
  logic [DATA_W-1:0] upper, lower;

  sxu_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_s_n(rst_s_n)
  );

  assign ctrl_wr   = bus_wr_en && (bus_addr == ADDR_CTRL) && !busy;
  assign start_req = ctrl_wr && bus_wdata[CTRL_START];

  always_comb begin
    wide_n    = wide_q;
    tail_en_n = tail_en_q;
    if (ctrl_wr) begin
      wide_n    = bus_wdata[CTRL_WIDE];
      tail_en_n = bus_wdata[CTRL_TAILEN];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      wide_q    <= 1'b0;
      tail_en_q <= 1'b0;
    end else begin
      wide_q    <= wide_n;
      tail_en_q <= tail_en_n;
    end
  end

  sxu_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .run     (busy),
    .fall_evt(fall_evt),
    .rise_evt(rise_evt),
    .sclk    (sclk_o)
  );

  sxu_seq #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .start_req(start_req),
    .wide     (wide_q),
    .tail_en  (tail_en_q),
    .fall_evt (fall_evt),
    .rise_evt (rise_evt),
    .lsb_i    (lower[0]),
    .busy     (busy),
    .phase    (phase),
    .shift_en (shift_en),
    .sdo      (sdo_o),
    .done     (done_o)
  );

  sxu_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk     (clk),
    .wr_upper(bus_wr_en && (bus_addr == ADDR_UPPER)),
    .wr_lower(bus_wr_en && (bus_addr == ADDR_LOWER)),
    .wdata   (bus_wdata),
    .shift_en(shift_en),
    .wide    (wide_q),
    .sdi     (sdi_i),
    .upper   (upper),
    .lower   (lower)
  );

  assign tail_flag = (phase == PH_TAIL);

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_CTRL: begin
        bus_rdata[CTRL_START]  = busy;
        bus_rdata[CTRL_TAILST] = tail_flag;
        bus_rdata[CTRL_WIDE]   = wide_q;
        bus_rdata[CTRL_TAILEN] = tail_en_q;
      end
      ADDR_UPPER: bus_rdata = upper;
      ADDR_LOWER: bus_rdata = lower;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sxu_checker.sv
module sxu_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic tail_flag,
  input logic tail_en,
  input logic wide,
  input logic sclk,
  input logic sdo,
  input logic done
);
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk); // R11
  AST_TAIL_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tail_flag |-> busy); // R8
  AST_TAIL_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    tail_flag |-> tail_en); // R8
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_SDO_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdo)); // R4
  AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(wide) && $stable(tail_en))); // R3
endmodule

bind serial_xfer_unit sxu_checker u_sxu_chk (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .busy     (busy),
  .tail_flag(tail_flag),
  .tail_en  (tail_en_q),
  .wide     (wide_q),
  .sclk     (sclk_o),
  .sdo      (sdo_o),
  .done     (done_o)
);

// File: tb/serial_xfer_unit_tb.sv
`timescale 1ns/1ps
module serial_xfer_unit_tb;
  localparam int DATA_W  = 8;
  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;

  logic              clk;
  logic              rst_n;
  logic              bus_wr_en;
  logic [1:0]        bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              sclk_o, sdo_o, sdi_i, done_o;
  logic              sdi_force, sdi_val;

  int check_cnt = 0;
  int fail_cnt  = 0;
  bit finished  = 0;

  // monitor state
  int   busy_cnt, tail_cnt, tail_in_data, rise_cnt, done_cnt, done_ok;
  logic sdo_seen [0:39];
  logic prev_sclk, prev_busy;

  assign sdi_i = sdi_force ? sdi_val : sdo_o;

  serial_xfer_unit #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_o(sclk_o),
    .sdo_o(sdo_o), .sdi_i(sdi_i), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_addr == 2'd0) begin
        if (bus_rdata[0]) busy_cnt++;
        if (bus_rdata[1]) begin
          tail_cnt++;
          if (rise_cnt < 8 && !sdo_seen_tail_ok()) tail_in_data++;
        end
      end
      if (sclk_o && !prev_sclk) begin
        if (rise_cnt < 40) sdo_seen[rise_cnt] = sdo_o;
        rise_cnt++;
      end
      if (done_o) begin
        done_cnt++;
        if (bus_addr == 2'd0 && !bus_rdata[0] && prev_busy) done_ok++;
      end
      prev_sclk = sclk_o;
      prev_busy = (bus_addr == 2'd0) ? bus_rdata[0] : prev_busy;
    end
  end

  int cur_nbits;
  function automatic bit sdo_seen_tail_ok();
    return rise_cnt >= cur_nbits;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    check_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr_en = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    @(posedge clk); #1;
    bus_addr = 2'd0;
  endtask

  task automatic clear_mon(input int nbits);
    busy_cnt = 0; tail_cnt = 0; tail_in_data = 0; rise_cnt = 0;
    done_cnt = 0; done_ok = 0; cur_nbits = nbits;
    for (int i = 0; i < 40; i++) sdo_seen[i] = 1'bx;
  endtask

  task automatic wait_idle();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (bus_rdata[0] && guard < 1000);
    repeat (4) @(negedge clk);
  endtask

  // R1
  task automatic t_reset();
    logic [7:0] r;
    bus_read(2'd0, r);
    check(r == 8'h00, "R1 ctrl after reset", r, 0);
    check(sclk_o == 1'b1, "R1 sclk idle", sclk_o, 1);
    check(sdo_o == 1'b1, "R1 sdo idle", sdo_o, 1);
    check(done_o == 1'b0, "R1 done low", done_o, 0);
  endtask

  task automatic run_xfer(input bit wide, input bit tail, input logic [7:0] lo,
                          input logic [7:0] up, input bit force_in, input bit fval);
    int nb, slots, n;
    logic [7:0] r;
    logic [15:0] word;
    logic [7:0] exp_lo, exp_up;
    nb    = wide ? 16 : 8;
    slots = nb + (tail ? 2 : 0);
    word  = {up, lo};
    sdi_force = force_in; sdi_val = fval;
    bus_write(2'd2, lo);
    bus_write(2'd1, up);
    clear_mon(nb);
    bus_write(2'd0, {4'b0, tail, wide, 1'b0, 1'b1});
    wait_idle();
    check(busy_cnt == slots * CLK_DIV, "R2 busy length", busy_cnt, slots * CLK_DIV);
    check(rise_cnt == slots, "R11 sclk rises", rise_cnt, slots);
    n = 0;
    for (int i = 0; i < nb; i++) if (sdo_seen[i] !== word[i]) n++;
    check(n == 0, wide ? "R5 wide bit order" : "R4 lsb-first order", n, 0);
    if (tail) begin
      check(sdo_seen[nb] === 1'b1 && sdo_seen[nb+1] === 1'b0, "R7 tail pattern",
            {sdo_seen[nb], sdo_seen[nb+1]}, 2);
    end
    check(tail_cnt == (tail ? 2 * CLK_DIV - HALF : 0), "R8 tail flag cycles",
          tail_cnt, tail ? 2 * CLK_DIV - HALF : 0);
    check(tail_in_data == 0, "R8 tail flag in data phase", tail_in_data, 0);
    check(done_cnt == 1 && done_ok == 1, "R10 done pulse", done_cnt * 10 + done_ok, 11);
    exp_lo = force_in ? {8{fval}} : lo;
    exp_up = force_in ? (wide ? {8{fval}} : up) : up;
    bus_read(2'd2, r);
    check(r == exp_lo, "R6 lower after transfer", r, exp_lo);
    bus_read(2'd1, r);
    check(r == exp_up, "R6 upper after transfer", r, exp_up);
    sdi_force = 1'b0;
    bus_write(2'd0, 8'h00);
  endtask

  // R3 / R9
  task automatic t_ctrl_writes();
    logic [7:0] r;
    clear_mon(8);
    bus_write(2'd0, 8'h00);
    repeat (20) @(negedge clk);
    check(rise_cnt == 0 && busy_cnt == 0, "R3 write zero no start", rise_cnt + busy_cnt, 0);
    bus_write(2'd0, 8'h02);
    bus_read(2'd0, r);
    check(r == 8'h00, "R9 tail status read-only", r, 0);
    bus_write(2'd0, 8'h0C);
    bus_read(2'd0, r);
    check(r == 8'h0C, "R3 mode bits writable idle", r, 12);
    bus_write(2'd0, 8'h00);
  endtask

  // R3 / R10: control write landing on the finishing edge
  task automatic t_collision();
    logic [7:0] r;
    bus_write(2'd2, 8'h5A);
    clear_mon(8);
    bus_write(2'd0, 8'h01);
    repeat (30) @(posedge clk);
    bus_write(2'd0, 8'h0D);
    repeat (20) @(negedge clk);
    check(busy_cnt == 8 * CLK_DIV, "R3 collision busy length", busy_cnt, 8 * CLK_DIV);
    check(rise_cnt == 8, "R3 no restart after collision", rise_cnt, 8);
    check(done_cnt == 1, "R10 single done at collision", done_cnt, 1);
    bus_read(2'd0, r);
    check(r == 8'h00, "R3 collision write dropped", r, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    sdi_force = 1'b0; sdi_val = 1'b0;
    prev_sclk = 1'b1; prev_busy = 1'b0; cur_nbits = 8;
    clear_mon(8);
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    run_xfer(1'b0, 1'b0, 8'hA5, 8'h00, 1'b0, 1'b0);
    run_xfer(1'b0, 1'b1, 8'h3C, 8'h00, 1'b0, 1'b0);
    run_xfer(1'b1, 1'b0, 8'h96, 8'h1E, 1'b0, 1'b0);
    run_xfer(1'b1, 1'b1, 8'h01, 8'h80, 1'b0, 1'b0);
    run_xfer(1'b0, 1'b0, 8'h00, 8'h55, 1'b1, 1'b1);
    run_xfer(1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1);
    t_ctrl_writes();
    t_collision();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", check_cnt, fail_cnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check_cnt++;
      fail_cnt++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", check_cnt, fail_cnt);
      $finish;
    end
  end
endmodule